// File: doc/BRIEF.md
# Serial DAC Input Register Controller

This block is the digital front end of a 10-bit voltage-output DAC. A host sends 16-bit frames over a three-wire serial link made of a bit clock, an active-low frame select and a data line. The block samples data on falling bit-clock edges and loads a DAC code register and a two-bit operating mode when a frame completes. The resistor string, the output amplifier and the termination switches sit outside the block. It drives their code and control lines.

The serial inputs are asynchronous to the system clock. A two-stage synchronizer brings them into the system clock domain, and edges are detected there. If frame select rises before the sixteenth falling edge, the frame is thrown away and no register changes. Frame bits 13:12 pick normal operation or one of three power-down terminations. Power-down leaves the stored code as it is. When the mode goes from power-down back to normal, a wake-up timer holds the ready flag low for a fixed number of system clocks.

Top module: `dac_serial_front`

## Requirements
- R1: While reset is active, and right after it ends, dac_code is 0, op_mode is 00, amp_en is 1, term_sel is 000 and out_ready is 1.
- R2: A frame is 16 bits, sent most significant bit first. DIN is sampled on each falling SCLK edge while SYNC_N is low. On the 16th falling edge, dac_code takes frame bits 11:2 and op_mode takes frame bits 13:12. The outputs change after the third rising clk edge that samples the 16th SCLK low level.
- R3: Frame bits 15, 14, 1 and 0 have no effect on any output.
- R4: If SYNC_N goes high before the 16th falling edge, the partial frame is dropped and no output changes. The next frame is collected from its first bit.
- R5: While SYNC_N stays low, falling SCLK edges after the 16th are ignored until SYNC_N goes high again.
- R6: op_mode 00 gives amp_en=1 and term_sel=000. Mode 01 gives term_sel=001 (1 kOhm to ground). Mode 10 gives 010 (100 kOhm to ground). Mode 11 gives 100 (open output). amp_en is 0 in every power-down mode.
- R7: A frame whose mode field is not 00 changes only op_mode. dac_code keeps its earlier value through power-down and back into normal operation.
- R8: out_ready is 0 in every power-down mode. After op_mode goes from power-down to 00, it stays 0 for WAKE_CYCLES clocks and then returns to 1.
- R9: If SYNC_N rises in the same synchronized sample as the 16th falling SCLK edge, the frame counts as aborted and nothing changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| sclk | input | 1 | Serial bit clock; data is taken on its falling edge |
| sync_n | input | 1 | Active-low frame select |
| din | input | 1 | Serial data, most significant bit first |
| dac_code | output | 10 | Code driven to the resistor string |
| op_mode | output | 2 | Operating mode: 00 normal, 01/10/11 power-down |
| amp_en | output | 1 | Output amplifier enable |
| term_sel | output | 3 | One-hot termination select: 1k, 100k, open |
| out_ready | output | 1 | High when the output is in normal mode and settled |

## Verification
Two of the block's functions can act in the same synchronized sample: an abort by frame select and the sixteenth falling edge that would finish a frame. The bench provokes this by driving SCLK low and SYNC_N high on the same clock. The abort must win, and the check is that code, mode and ready all stay unchanged. A second overlap happens when a power-down frame lands while the wake-up timer is still counting. A cycle-by-cycle reference model in the bench judges every output on every clock.

// File: rtl/dac_fe_pkg.sv
package dac_fe_pkg;

    typedef enum logic [1:0] {
        MODE_RUN     = 2'b00,
        MODE_PD_1K   = 2'b01,
        MODE_PD_100K = 2'b10,
        MODE_PD_OPEN = 2'b11
    } op_mode_e;

    localparam int TERM_W = 3;

    function automatic logic [TERM_W-1:0] term_decode(op_mode_e m);
        logic [TERM_W-1:0] t;
        t = '0;
        case (m)
            MODE_PD_1K:   t[0] = 1'b1;
            MODE_PD_100K: t[1] = 1'b1;
            MODE_PD_OPEN: t[2] = 1'b1;
            default:      t = '0;
        endcase
        return t;
    endfunction

endpackage

// File: rtl/dac_in_sync.sv
module dac_in_sync #(
    parameter int           W       = 3,
    parameter int           STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] d_out
);

    logic [W-1:0] stage_d [STAGES];
    logic [W-1:0] stage_q [STAGES];

    always_comb begin
        stage_d[0] = d_in;
        for (int i = 1; i < STAGES; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[g] <= RST_VAL;
                else        stage_q[g] <= stage_d[g];
            end
        end
    endgenerate

    assign d_out = stage_q[STAGES-1];

endmodule

// File: rtl/dac_frame_rx.sv
module dac_frame_rx #(
    parameter int FRAME_BITS = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sclk_s,
    input  logic                  sync_n_s,
    input  logic                  din_s,
    output logic                  word_vld,
    output logic [FRAME_BITS-1:0] word
);

    localparam int            CW   = $clog2(FRAME_BITS + 1);
    localparam logic [CW-1:0] LAST = CW'(FRAME_BITS - 1);
    localparam logic [CW-1:0] FULL = CW'(FRAME_BITS);

    typedef struct packed {
        logic                  sclk_prev;
        logic [CW-1:0]         cnt;
        logic [FRAME_BITS-1:0] shreg;
    } rx_st_t;

    rx_st_t st_d, st_q;
    logic   fall;

    always_comb begin
        st_d           = st_q;
        st_d.sclk_prev = sclk_s;
        fall           = st_q.sclk_prev & ~sclk_s;
        word           = {st_q.shreg[FRAME_BITS-2:0], din_s};
        word_vld       = 1'b0;
        if (sync_n_s) begin
            st_d.cnt   = '0;
            st_d.shreg = '0;
        end else if (fall && (st_q.cnt < FULL)) begin
            st_d.shreg = word;
            st_d.cnt   = st_q.cnt + 1'b1;
            word_vld   = (st_q.cnt == LAST);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sclk_prev <= 1'b1;
            st_q.cnt       <= '0;
            st_q.shreg     <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= FULL);

    p_abort_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sync_n_s |=> (st_q.cnt == '0) && (st_q.shreg == '0));

    p_done_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld |=> (st_q.cnt == FULL));

    p_no_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sync_n_s |-> !word_vld);

endmodule

// File: rtl/dac_wake_timer.sv
module dac_wake_timer #(
    parameter int WAKE_CYCLES = 125
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic stop,
    output logic busy
);

    localparam int            CW   = (WAKE_CYCLES > 0) ? $clog2(WAKE_CYCLES + 1) : 1;
    localparam logic [CW-1:0] LOAD = CW'(WAKE_CYCLES);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (stop)                cnt_d = '0;
        else if (start)          cnt_d = LOAD;
        else if (cnt_q != '0)    cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy = (cnt_q != '0);

    p_stop_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> !busy);

    p_count_down_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !start && !stop) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/dac_serial_front.sv
module dac_serial_front #(
    parameter int FRAME_BITS  = 16,
    parameter int CODE_W      = 10,
    parameter int CODE_LSB    = 2,
    parameter int MODE_LSB    = 12,
    parameter int SYNC_STAGES = 2,
    parameter int WAKE_CYCLES = 125
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk,
    input  logic              sync_n,
    input  logic              din,
    output logic [CODE_W-1:0] dac_code,
    output logic [1:0]        op_mode,
    output logic              amp_en,
    output logic [2:0]        term_sel,
    output logic              out_ready
);

    import dac_fe_pkg::*;

    typedef struct packed {
        logic [CODE_W-1:0] code;
        op_mode_e          mode;
    } out_st_t;

    logic [2:0]            pins_s;
    logic                  word_vld;
    logic [FRAME_BITS-1:0] word;
    logic                  wake_busy;
    logic                  wake_start, wake_stop;
    op_mode_e              new_mode;
    out_st_t               st_d, st_q;

    dac_in_sync #(
        .W      (3),
        .STAGES (SYNC_STAGES),
        .RST_VAL(3'b110)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d_in ({sclk, sync_n, din}),
        .d_out(pins_s)
    );

    dac_frame_rx #(
        .FRAME_BITS(FRAME_BITS)
    ) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .sclk_s  (pins_s[2]),
        .sync_n_s(pins_s[1]),
        .din_s   (pins_s[0]),
        .word_vld(word_vld),
        .word    (word)
    );

    always_comb begin
        st_d     = st_q;
        new_mode = op_mode_e'(word[MODE_LSB +: 2]);
        if (word_vld) begin
            st_d.mode = new_mode;
            if (new_mode == MODE_RUN) begin
                st_d.code = word[CODE_LSB +: CODE_W];
            end
        end
        wake_start = (st_q.mode != MODE_RUN) && (st_d.mode == MODE_RUN);
        wake_stop  = (st_d.mode != MODE_RUN);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.code <= '0;
            st_q.mode <= MODE_RUN;
        end else begin
            st_q <= st_d;
        end
    end

    dac_wake_timer #(
        .WAKE_CYCLES(WAKE_CYCLES)
    ) u_wake (
        .clk  (clk),
        .rst_n(rst_n),
        .start(wake_start),
        .stop (wake_stop),
        .busy (wake_busy)
    );

    assign dac_code  = st_q.code;
    assign op_mode   = st_q.mode;
    assign amp_en    = (st_q.mode == MODE_RUN);
    assign term_sel  = term_decode(st_q.mode);
    assign out_ready = (st_q.mode == MODE_RUN) && !wake_busy;

    p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !word_vld |=> $stable(st_q));

    p_pd_keeps_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (word_vld && (word[MODE_LSB +: 2] != 2'b00)) |=> $stable(st_q.code));

    p_term_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(term_sel) && (amp_en == (term_sel == 3'b000)));

    p_pd_not_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_mode != 2'b00) |-> !out_ready);

    generate
        if (WAKE_CYCLES > 0) begin : g_wake_chk
            p_wake_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
                (op_mode != 2'b00) ##1 (op_mode == 2'b00) |-> !out_ready);
        end
    endgenerate

endmodule

// File: tb/sim_dac_serial_front.sv
`timescale 1ns/1ps
module sim_dac_serial_front;

    localparam int WAKE = 125;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sclk = 1'b1;
    logic       sync_n = 1'b1;
    logic       din = 1'b0;
    logic [9:0] dac_code;
    logic [1:0] op_mode;
    logic       amp_en;
    logic [2:0] term_sel;
    logic       out_ready;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #10 clk = ~clk;

    dac_serial_front #(.WAKE_CYCLES(WAKE)) u0 (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .sync_n(sync_n), .din(din),
        .dac_code(dac_code), .op_mode(op_mode), .amp_en(amp_en),
        .term_sel(term_sel), .out_ready(out_ready)
    );

    // behavioural reference: input samples seen at each edge, delayed by the synchronizer
    bit h_sclk [4];
    bit h_sync [4];
    bit h_din  [4];
    int m_cnt, m_bits, m_code, m_mode, m_wait;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) begin
                h_sclk[i] = 1; h_sync[i] = 1; h_din[i] = 0;
            end
            m_cnt = 0; m_bits = 0; m_code = 0; m_mode = 0; m_wait = 0;
        end else begin
            int old_mode;
            for (int i = 3; i > 0; i--) begin
                h_sclk[i] = h_sclk[i-1]; h_sync[i] = h_sync[i-1]; h_din[i] = h_din[i-1];
            end
            h_sclk[0] = sclk; h_sync[0] = sync_n; h_din[0] = din;
            old_mode = m_mode;
            if (h_sync[2]) begin
                m_cnt = 0; m_bits = 0;
            end else if (h_sclk[3] && !h_sclk[2] && m_cnt < 16) begin
                m_bits = ((m_bits << 1) | int'(h_din[2])) & 16'hFFFF;
                m_cnt++;
                if (m_cnt == 16) begin
                    m_mode = (m_bits >> 12) & 3;
                    if (m_mode == 0) m_code = (m_bits >> 2) & 10'h3FF;
                end
            end
            if (m_mode != 0)        m_wait = 0;
            else if (old_mode != 0) m_wait = WAKE;
            else if (m_wait > 0)    m_wait--;
        end
    end

    function automatic int exp_term(int m);
        return (m == 1) ? 1 : (m == 2) ? 2 : (m == 3) ? 4 : 0;
    endfunction

    string cur_req = "R1";

    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (dac_code !== 10'(m_code) || op_mode !== 2'(m_mode) ||
                amp_en !== (m_mode == 0) || term_sel !== 3'(exp_term(m_mode)) ||
                out_ready !== (m_mode == 0 && m_wait == 0)) begin
                errors++;
                $display("FAIL %s per-cycle: got code=%h mode=%0d amp=%0b term=%b rdy=%0b exp code=%h mode=%0d rdy=%0b",
                         cur_req, dac_code, op_mode, amp_en, term_sel, out_ready,
                         m_code, m_mode, (m_mode == 0 && m_wait == 0));
            end
        end
    end

    task automatic chk(string req, int got, int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, got, exp);
        end
    endtask

    task automatic wclk(int n);
        repeat (n) @(negedge clk);
    endtask

    // nbits: bits before SYNC_N rises; extra: falls after the 16th; race: abort on 16th fall
    task automatic send(logic [15:0] w, int nbits, int extra, bit race);
        sync_n = 1'b0;
        wclk(3);
        for (int i = 0; i < nbits; i++) begin
            din = w[15-i];
            sclk = 1'b1;
            wclk(3);
            if (race && i == 15) begin
                sclk = 1'b0; sync_n = 1'b1;
            end else begin
                sclk = 1'b0;
            end
            wclk(3);
        end
        for (int i = 0; i < extra; i++) begin
            din = 1'b1; sclk = 1'b1; wclk(3);
            sclk = 1'b0; wclk(3);
        end
        sclk = 1'b1;
        wclk(3);
        sync_n = 1'b1;
        wclk(8);
    endtask

    function automatic int code_of(logic [15:0] w);
        return int'(w[11:2]);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        wclk(5);
        rst_n = 1'b1;
        wclk(2);
        cur_req = "R1";
        chk("R1 code", int'(dac_code), 0);
        chk("R1 mode", int'(op_mode), 0);
        chk("R1 ready", int'(out_ready), 1);
        chk("R1 amp", int'(amp_en), 1);
        chk("R1 term", int'(term_sel), 0);

        cur_req = "R2";
        send(16'h0A5C, 16, 0, 0);
        chk("R2 code", int'(dac_code), code_of(16'h0A5C));
        chk("R2 mode", int'(op_mode), 0);

        cur_req = "R3";
        send(16'hC003, 16, 0, 0);
        chk("R3 code ignores DB15/14/1/0", int'(dac_code), 0);
        send(16'hCFFF, 16, 0, 0);
        chk("R3 code", int'(dac_code), 10'h3FF);

        cur_req = "R4";
        send(16'h0155, 9, 0, 0);
        chk("R4 abort keeps code", int'(dac_code), 10'h3FF);
        chk("R4 abort keeps mode", int'(op_mode), 0);
        send(16'h0155, 16, 0, 0);
        chk("R4 next frame clean", int'(dac_code), code_of(16'h0155));

        cur_req = "R5";
        send(16'h0800, 16, 5, 0);
        chk("R5 extra edges ignored", int'(dac_code), 10'h200);
        chk("R5 mode", int'(op_mode), 0);

        cur_req = "R6";
        send(16'h13FC, 16, 0, 0);
        chk("R6 mode 01", int'(op_mode), 1);
        chk("R6 term 1k", int'(term_sel), 3'b001);
        chk("R6 amp off", int'(amp_en), 0);
        chk("R7 code kept in pd", int'(dac_code), 10'h200);
        chk("R8 not ready in pd", int'(out_ready), 0);
        send(16'h2000, 16, 0, 0);
        chk("R6 term 100k", int'(term_sel), 3'b010);
        send(16'h3000, 16, 0, 0);
        chk("R6 term open", int'(term_sel), 3'b100);
        chk("R7 code kept", int'(dac_code), 10'h200);

        cur_req = "R8";
        send(16'h0000 | (16'h0200 << 2), 16, 0, 0);
        chk("R8 ready low after wake", int'(out_ready), 0);
        chk("R7 code after return", int'(dac_code), 10'h200);
        wclk(WAKE / 2);
        chk("R8 still waking", int'(out_ready), 0);
        wclk(WAKE);
        chk("R8 ready back", int'(out_ready), 1);

        // power-down entered while the wake timer is counting
        send(16'h1000, 16, 0, 0);
        send(16'h0404, 16, 0, 0);
        wclk(20);
        send(16'h2000, 16, 0, 0);
        chk("R8 pd during wake", int'(out_ready), 0);
        send(16'h0404, 16, 0, 0);
        wclk(WAKE + 5);
        chk("R8 ready after second wake", int'(out_ready), 1);
        chk("R2 code", int'(dac_code), 10'h101);

        cur_req = "R9";
        send(16'h1FFC, 16, 0, 1);
        chk("R9 race abort code", int'(dac_code), 10'h101);
        chk("R9 race abort mode", int'(op_mode), 0);
        chk("R9 ready kept", int'(out_ready), 1);

        wclk(4);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule